// File: doc/BRIEF.md
# Cascadable Dual Event Counter

This block counts rising edges on two external event inputs that have no timing relationship to the system clock. It holds two 8-bit up-counters, a low half and a high half. Each event input first passes through a synchronizer and a rising-edge detector. The result is a single-cycle increment request in the system clock domain.

A control register has one run bit for each half and one chaining bit. While a run bit is 0, its counter is held at zero. Writing it to 1 lets the counter advance. The chaining bit chooses what drives the high half:

- When it is 0, the high half counts its own event input.
- When it is 1, the high half counts wrap-arounds of the low half. The pair then acts as one 16-bit counter, with the low half as the least significant byte.

Software reaches the control register and both count values through a small register port. The port has a 2-bit address, a write strobe and a registered read-data bus.

Top module: `dual_event_counter`

## Requirements
- R1: After synchronous reset the control register reads 0x00 and both counts read 0x00.
- R2: While a half's run bit is 0, that half's count stays at 0x00 and its event input has no effect.
- R3: With the low run bit (control bit 0) at 1, the low count goes up by exactly one per rising edge of its event input. An input held high counts once.
- R4: With the chaining bit (control bit 2) at 0 and the high run bit (control bit 1) at 1, the high count goes up by one per rising edge of the high event input. Low-input edges do not change it.
- R5: With the chaining bit at 1, the high count goes up in the same cycle that the low count wraps from 0xFF to 0x00. The pair therefore steps from 0x00FF to 0x0100.
- R6: With the chaining bit at 1, rising edges on the high event input do not change the high count.
- R7: Writing a run bit back to 0 clears its counter to 0x00 and leaves the other counter untouched. This is the only way to clear a counter.
- R8: While the low run bit is 0, the low half never produces a wrap pulse. In chained mode the high count stays constant even while low-input edges arrive.
- R9: Register map: address 0 is control, read/write, with all 8 bits stored. Address 1 returns the live low count and address 2 the live high count, both read-only. Address 3 reads 0x00. Read data appears one clock after the address is presented, with no snapshot latching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lo_i | input | 1 | Asynchronous event input of the low half |
| evt_hi_i | input | 1 | Asynchronous event input of the high half |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe; writes take effect only at address 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |

## Verification
The assertions check the following on every cycle:

- A held counter is zero on the next cycle.
- A running counter either holds or steps by exactly one.
- Each edge detector pulses for one cycle only.
- In chained mode, the high half advances on a low wrap and ignores its own pin in the other cycles.
- A low half held in reset never signals a wrap.

Only the bench scenarios can show the end-to-end behaviour. These include the count seen through the register port after real pin activity, the single count for a long-held input, the 0x00FF to 0x0100 rollover, and selective clearing through the run bits.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ADDR_W      = 2;
  localparam int BIT_RUN_LO  = 0;
  localparam int BIT_RUN_HI  = 1;
  localparam int BIT_CASCADE = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_RSVD = 2'd3
  } evc_addr_e;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], async_in};
  end

  // rising edge seen between the last synchronizer flop and its delayed copy
  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R3: one input edge yields a single-cycle request
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/evc_half_counter.sv
module evc_half_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) count <= '0;
    else if (inc)    count <= count + ONE;
  end

  assign wrap = run & inc & (&count);

  assert_hold_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> count == '0);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (run && inc) |=> count == W'($past(count) + ONE));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !inc) |=> $stable(count));
endmodule

// File: rtl/evc_regs.sv
module evc_regs
  import evc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] lo_count,
  input  logic [DATA_W-1:0] hi_count,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst)                                 ctrl_q <= '0;
    else if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: rd_mux = ctrl_q;
      ADDR_LO:   rd_mux = lo_count;
      ADDR_HI:   rd_mux = hi_count;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_RSVD) |=> bus_rdata == '0);
endmodule

// File: rtl/dual_event_counter.sv
module dual_event_counter
  import evc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_lo_i,
  input  logic              evt_hi_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int NUM_HALF = 2;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [NUM_HALF-1:0] evt_raw;
  logic [NUM_HALF-1:0] evt_rise;
  logic [DATA_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]   lo_count;
  logic [DATA_W-1:0]   hi_count;
  logic                lo_wrap;
  logic                hi_wrap;
  logic                hi_inc;
  logic                run_lo;
  logic                run_hi;
  logic                cascade;

  assign evt_raw = {evt_hi_i, evt_lo_i};

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_sync
    evc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .async_in  (evt_raw[g]),
      .rise_pulse(evt_rise[g])
    );
  end

  assign run_lo  = ctrl_q[BIT_RUN_LO];
  assign run_hi  = ctrl_q[BIT_RUN_HI];
  assign cascade = ctrl_q[BIT_CASCADE];
  assign hi_inc  = cascade ? lo_wrap : evt_rise[1];

  evc_half_counter #(.W(DATA_W)) u_lo (
    .clk  (clk),
    .rst  (rst),
    .run  (run_lo),
    .inc  (evt_rise[0]),
    .count(lo_count),
    .wrap (lo_wrap)
  );

  evc_half_counter #(.W(DATA_W)) u_hi (
    .clk  (clk),
    .rst  (rst),
    .run  (run_hi),
    .inc  (hi_inc),
    .count(hi_count),
    .wrap (hi_wrap)
  );

  evc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .lo_count (lo_count),
    .hi_count (hi_count),
    .ctrl_q   (ctrl_q),
    .bus_rdata(bus_rdata)
  );

  assert_cascade_step_R5: assert property (@(posedge clk) disable iff (rst)
    (cascade && run_hi && lo_wrap) |=> hi_count == DATA_W'($past(hi_count) + ONE));

  assert_cascade_pin_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cascade && run_hi && !lo_wrap) |=> $stable(hi_count));

  assert_indep_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!cascade && run_hi && evt_rise[1]) |=> hi_count == DATA_W'($past(hi_count) + ONE));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    !run_lo |-> !lo_wrap);

  // the high half's own wrap drives nothing; it is checked for sanity only
  assert_hi_wrap_gated_R2: assert property (@(posedge clk) disable iff (rst)
    !run_hi |-> !hi_wrap);
endmodule

// File: tb/dual_event_counter_tb.sv
module dual_event_counter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       evt_lo_i;
  logic       evt_hi_i;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] exp;
    logic [1:0] addr;
    string      req;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;

  always #2 clk = ~clk;

  dual_event_counter u_dut (
    .clk      (clk),
    .rst      (rst),
    .evt_lo_i (evt_lo_i),
    .evt_hi_i (evt_hi_i),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // monitor: pops the expected item for each completed read
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: read with no expected item");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%0d actual=0x%02h expected=0x%02h",
                   it.req, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] data);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic check_read(input logic [1:0] addr, input logic [7:0] exp, input string req);
    item_t it;
    it.exp = exp; it.addr = addr; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    bus_addr = addr;
    @(posedge clk);
    @(negedge clk);
    -> sample_ev;
  endtask

  task automatic pulse_lo(input int n, input int high_cycles);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_lo_i = 1'b1;
      repeat (high_cycles) @(negedge clk);
      evt_lo_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulse_hi(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_hi_i = 1'b1;
      repeat (4) @(negedge clk);
      evt_hi_i = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; evt_lo_i = 1'b0; evt_hi_i = 1'b0;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    check_read(2'd0, 8'h00, "R1 ctrl after reset");
    check_read(2'd1, 8'h00, "R1 low after reset");
    check_read(2'd2, 8'h00, "R1 high after reset");

    pulse_lo(3, 4);
    pulse_hi(2);
    check_read(2'd1, 8'h00, "R2 low held ignores events");
    check_read(2'd2, 8'h00, "R2 high held ignores events");

    bus_write(8'h03);
    check_read(2'd0, 8'h03, "R9 ctrl readback");
    pulse_lo(4, 4);
    check_read(2'd1, 8'h04, "R3 low counts edges");
    pulse_lo(1, 20);
    check_read(2'd1, 8'h05, "R3 long high counts once");
    check_read(2'd2, 8'h00, "R4 low edges do not move high");
    pulse_hi(3);
    check_read(2'd2, 8'h03, "R4 high counts own pin");
    check_read(2'd1, 8'h05, "R9 live low value");
    check_read(2'd3, 8'h00, "R9 reserved address");

    bus_write(8'h01);
    check_read(2'd2, 8'h00, "R7 high cleared");
    check_read(2'd1, 8'h05, "R7 low untouched");
    bus_write(8'h00);
    check_read(2'd1, 8'h00, "R7 low cleared");

    bus_write(8'h07);
    pulse_hi(4);
    check_read(2'd2, 8'h00, "R6 cascade ignores high pin");
    pulse_lo(255, 2);
    check_read(2'd1, 8'hFF, "R5 low at 0xFF");
    check_read(2'd2, 8'h00, "R5 high at 0x00");
    pulse_lo(1, 2);
    check_read(2'd1, 8'h00, "R5 low wrapped");
    check_read(2'd2, 8'h01, "R5 high stepped to 0x01");

    bus_write(8'h06);
    pulse_lo(10, 2);
    check_read(2'd1, 8'h00, "R8 low held");
    check_read(2'd2, 8'h01, "R8 no overflow from held low");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items unread (actual) expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule